// File: doc/BRIEF.md
# Dual-Clock Shared Memory with Per-Port Width Shapes

This block is a true dual-port synchronous memory holding 16,384 data bits and 2,048 parity bits. Each of its two ports runs on its own clock and has its own enable, write enable, address, data input, parity input, data output and parity output. A parameter per port picks the port's width, from 1 bit up to 32 bits in powers of two. The address width shrinks as the port gets wider. At widths of 8 bits and above, each data byte carries one parity bit.

Both ports address the same storage. A value written through a narrow port can be read back through a wide one, and the reverse. A second parameter per port chooses what the port's output register shows while that port writes: the new data, the old contents, or its previous value unchanged. The output registers clear on an asynchronous active-low reset for each port. The stored contents are not cleared.

Top module: `dpr_aspect_ram`

## Requirements
- R1: For port width W in {1,2,4,8,16,32}, the address is 14 - log2(W) bits wide and the parity lane is W/8 bits wide for W >= 8. For W < 8 the parity lane is 0 bits: a 1-bit parity port is still present, its input is ignored and its output stays 0.
- R2: On a clock edge with enable and write enable both high, the data input is stored at data-space bits a*W to a*W+W-1 of the 16,384-bit data space.
- R3: The parity input of a write is stored at bits a*P to a*P+P-1 of the 2,048-bit parity space, where P = W/8. Parity bit k therefore belongs to data byte k of the same 32-bit row.
- R4: On an edge with enable high and write enable low, the addressed data and parity appear on the outputs after that edge.
- R5: With write mode 0 (new data shown), a write also loads the written data and parity into the outputs.
- R6: With write mode 1 (old data shown), a write loads the contents the location held before the edge into the outputs.
- R7: With write mode 2 (output held), a write leaves both outputs unchanged.
- R8: With enable low, the outputs hold their value and nothing is written, even when write enable is high.
- R9: While a port's reset input is low, its data and parity outputs are 0. Reset does not alter the stored contents.
- R10: Data written through one port's shape reads back through the other port's shape at the bit positions given by R2 and R3, with each port on its own clock.
- R11: Writes from both ports to disjoint bits of the same 32-bit row, made in the same cycle, both take effect and leave the other bits of the row intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_n_a | input | 1 | Port A asynchronous reset of the output registers, active low |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | 14-log2(WIDTH_A) | Port A address |
| din_a | input | WIDTH_A | Port A write data |
| par_in_a | input | max(WIDTH_A/8,1) | Port A write parity |
| dout_a | output | WIDTH_A | Port A registered read data |
| par_out_a | output | max(WIDTH_A/8,1) | Port A registered parity |
| clk_b | input | 1 | Port B clock |
| rst_n_b | input | 1 | Port B asynchronous reset of the output registers, active low |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | 14-log2(WIDTH_B) | Port B address |
| din_b | input | WIDTH_B | Port B write data |
| par_in_b | input | max(WIDTH_B/8,1) | Port B write parity |
| dout_b | output | WIDTH_B | Port B registered read data |
| par_out_b | output | max(WIDTH_B/8,1) | Port B registered parity |

## Verification
Two operations can fall on the same storage row in the same cycle. One is a narrow write through one port. The other is a wide write through the second port, which in old-data mode also reads back that row. The bench provokes this by forking a 4-bit write and a 16-bit write into different lanes of one 32-bit row. It judges the result in three ways. The wide port must return the row's earlier contents. The narrow port, in held-output mode, must keep its previous output. Reads through both shapes afterwards must show both new lanes and the untouched bits of the row.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int unsigned DATA_BITS  = 32;
  localparam int unsigned PAR_BITS   = DATA_BITS / 8;
  localparam int unsigned WORD_BITS  = DATA_BITS + PAR_BITS;
  localparam int unsigned TOTAL_DATA = 16384;
  localparam int unsigned MEM_WORDS  = TOTAL_DATA / DATA_BITS;
  localparam int unsigned IDX_W      = $clog2(MEM_WORDS);

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  function automatic int unsigned par_bits(int unsigned w);
    return (w >= 8) ? w / 8 : 0;
  endfunction

  function automatic int unsigned port_par(int unsigned w);
    return (par_bits(w) == 0) ? 1 : par_bits(w);
  endfunction

  function automatic int unsigned addr_bits(int unsigned w);
    return $clog2(TOTAL_DATA) - $clog2(w);
  endfunction

  function automatic int unsigned slots(int unsigned w);
    return DATA_BITS / w;
  endfunction

  function automatic int unsigned word_of(int unsigned a, int unsigned w);
    return a / slots(w);
  endfunction

  function automatic int unsigned lane_of(int unsigned a, int unsigned w);
    return (a % slots(w)) * w;
  endfunction
endpackage

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
module dpr_bank import dpr_pkg::*; #(
  parameter bit INVERT = 1'b0
) (
  input  logic                 clk,
  input  logic                 wr,
  input  logic [IDX_W-1:0]     widx,
  input  logic [WORD_BITS-1:0] wmask,
  input  logic [WORD_BITS-1:0] wdata,
  input  logic [WORD_BITS-1:0] peer_tog,
  input  logic [IDX_W-1:0]     ridx_a,
  input  logic [IDX_W-1:0]     ridx_b,
  output logic [WORD_BITS-1:0] dat_pa,
  output logic [WORD_BITS-1:0] tog_pa,
  output logic [WORD_BITS-1:0] dat_pb,
  output logic [WORD_BITS-1:0] tog_pb
);
  logic [WORD_BITS-1:0] dat_mem [MEM_WORDS];
  logic [WORD_BITS-1:0] tog_mem [MEM_WORDS];
  logic [WORD_BITS-1:0] tog_new;

  // Ownership bits: bank 0 makes the XOR zero, bank 1 makes it one.
  assign tog_new = INVERT ? ~peer_tog : peer_tog;

  always_ff @(posedge clk) begin
    if (wr) begin
      dat_mem[widx] <= (dat_mem[widx] & ~wmask) | (wdata & wmask);
      tog_mem[widx] <= (tog_mem[widx] & ~wmask) | (tog_new & wmask);
    end
  end

  assign dat_pa = dat_mem[ridx_a];
  assign tog_pa = tog_mem[ridx_a];
  assign dat_pb = dat_mem[ridx_b];
  assign tog_pb = tog_mem[ridx_b];
endmodule

// File: rtl/dpr_port.sv
`timescale 1ns/1ps
module dpr_port import dpr_pkg::*; #(
  parameter int unsigned W    = 8,
  parameter wmode_e      MODE = WM_WRITE_FIRST,
  localparam int unsigned AW  = addr_bits(W),
  localparam int unsigned PW  = par_bits(W),
  localparam int unsigned PX  = port_par(W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [W-1:0]         din,
  input  logic [PX-1:0]        par_in,
  input  logic [WORD_BITS-1:0] cur_word,
  output logic                 wr,
  output logic [IDX_W-1:0]     widx,
  output logic [WORD_BITS-1:0] wmask,
  output logic [WORD_BITS-1:0] wdata,
  output logic [W-1:0]         dout,
  output logic [PX-1:0]        par_out
);
  logic [5:0]           off;
  logic [5:0]           poff;
  logic [WORD_BITS-1:0] dmask, pmask, pdata;
  logic [W-1:0]         old_d;
  logic [PX-1:0]        old_p, par_new;

  assign wr    = en & we;
  assign widx  = IDX_W'(word_of(32'(addr), W));
  assign off   = 6'(lane_of(32'(addr), W));
  assign poff  = 6'(DATA_BITS) + {3'b000, off[5:3]};
  assign dmask = ((WORD_BITS'(1) << W) - WORD_BITS'(1)) << off;
  assign old_d = W'(cur_word >> off);

  if (PW == 0) begin : g_nopar
    logic unused_par;
    assign unused_par = ^par_in;
    assign pmask   = '0;
    assign pdata   = '0;
    assign old_p   = '0;
    assign par_new = '0;
  end else begin : g_par
    assign pmask   = ((WORD_BITS'(1) << PW) - WORD_BITS'(1)) << poff;
    assign pdata   = WORD_BITS'(par_in) << poff;
    assign old_p   = PX'(cur_word >> poff);
    assign par_new = par_in;
  end

  assign wmask = dmask | pmask;
  assign wdata = (WORD_BITS'(din) << off) | pdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      par_out <= '0;
    end else if (en) begin
      if (!we || MODE == WM_READ_FIRST) begin
        dout    <= old_d;
        par_out <= old_p;
      end else if (MODE == WM_WRITE_FIRST) begin
        dout    <= din;
        par_out <= par_new;
      end
    end
  end

  if (MODE == WM_WRITE_FIRST) begin : g_chk_wf
    a_r5_write_first: assert property (@(posedge clk) disable iff (!rst_n)
      (en && we) |=> (dout == $past(din)));
  end
  if (MODE == WM_NO_CHANGE) begin : g_chk_nc
    a_r7_no_change: assert property (@(posedge clk) disable iff (!rst_n)
      (en && we) |=> ($stable(dout) && $stable(par_out)));
  end

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(dout) && $stable(par_out)));

  a_r9_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (dout == '0 && par_out == '0));
endmodule

// File: rtl/dpr_aspect_ram.sv
`timescale 1ns/1ps
module dpr_aspect_ram import dpr_pkg::*; #(
  parameter int unsigned WIDTH_A = 8,
  parameter int unsigned WIDTH_B = 32,
  parameter wmode_e      MODE_A  = WM_WRITE_FIRST,
  parameter wmode_e      MODE_B  = WM_READ_FIRST,
  localparam int unsigned AW_A   = addr_bits(WIDTH_A),
  localparam int unsigned PX_A   = port_par(WIDTH_A),
  localparam int unsigned AW_B   = addr_bits(WIDTH_B),
  localparam int unsigned PX_B   = port_par(WIDTH_B)
) (
  input  logic               clk_a,
  input  logic               rst_n_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  input  logic [PX_A-1:0]    par_in_a,
  output logic [WIDTH_A-1:0] dout_a,
  output logic [PX_A-1:0]    par_out_a,
  input  logic               clk_b,
  input  logic               rst_n_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  input  logic [PX_B-1:0]    par_in_b,
  output logic [WIDTH_B-1:0] dout_b,
  output logic [PX_B-1:0]    par_out_b
);
  // Named internal events, visible to checkers.
  logic                 wr_a, wr_b;
  logic [IDX_W-1:0]     widx_a, widx_b;
  logic [WORD_BITS-1:0] wmask_a, wmask_b, wdata_a, wdata_b;
  logic [WORD_BITS-1:0] cur_word_a, cur_word_b, sel_a, sel_b;
  logic [WORD_BITS-1:0] ba_dat_pa, ba_tog_pa, ba_dat_pb, ba_tog_pb;
  logic [WORD_BITS-1:0] bb_dat_pa, bb_tog_pa, bb_dat_pb, bb_tog_pb;

  dpr_port #(.W(WIDTH_A), .MODE(MODE_A)) port_a_i (
    .clk(clk_a), .rst_n(rst_n_a), .en(en_a), .we(we_a), .addr(addr_a),
    .din(din_a), .par_in(par_in_a), .cur_word(cur_word_a), .wr(wr_a),
    .widx(widx_a), .wmask(wmask_a), .wdata(wdata_a), .dout(dout_a),
    .par_out(par_out_a));

  dpr_port #(.W(WIDTH_B), .MODE(MODE_B)) port_b_i (
    .clk(clk_b), .rst_n(rst_n_b), .en(en_b), .we(we_b), .addr(addr_b),
    .din(din_b), .par_in(par_in_b), .cur_word(cur_word_b), .wr(wr_b),
    .widx(widx_b), .wmask(wmask_b), .wdata(wdata_b), .dout(dout_b),
    .par_out(par_out_b));

  dpr_bank #(.INVERT(1'b0)) bank_a_i (
    .clk(clk_a), .wr(wr_a), .widx(widx_a), .wmask(wmask_a), .wdata(wdata_a),
    .peer_tog(bb_tog_pa), .ridx_a(widx_a), .ridx_b(widx_b),
    .dat_pa(ba_dat_pa), .tog_pa(ba_tog_pa), .dat_pb(ba_dat_pb), .tog_pb(ba_tog_pb));

  dpr_bank #(.INVERT(1'b1)) bank_b_i (
    .clk(clk_b), .wr(wr_b), .widx(widx_b), .wmask(wmask_b), .wdata(wdata_b),
    .peer_tog(ba_tog_pb), .ridx_a(widx_a), .ridx_b(widx_b),
    .dat_pa(bb_dat_pa), .tog_pa(bb_tog_pa), .dat_pb(bb_dat_pb), .tog_pb(bb_tog_pb));

  // Per bit, the bank whose ownership bit breaks the XOR balance wrote last.
  assign sel_a      = ba_tog_pa ^ bb_tog_pa;
  assign sel_b      = ba_tog_pb ^ bb_tog_pb;
  assign cur_word_a = (ba_dat_pa & ~sel_a) | (bb_dat_pa & sel_a);
  assign cur_word_b = (ba_dat_pb & ~sel_b) | (bb_dat_pb & sel_b);
endmodule

// File: tb/dpr_aspect_ram_tb.sv
`timescale 1ns/1ps
module dpr_aspect_ram_tb_top;
  import dpr_pkg::*;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_n_a = 1'b0, rst_n_b = 1'b0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2 clk_a = ~clk_a;                       // 250 MHz
  initial begin #2; forever #2 clk_b = ~clk_b; end // 250 MHz, opposite phase

  // DUT 1: A = 8 bit, new-data mode; B = 32 bit, old-data mode
  logic a_en = 0, a_we = 0; logic [10:0] a_addr = 0; logic [7:0] a_din = 0;
  logic [0:0] a_pin = 0; logic [7:0] a_dout; logic [0:0] a_pout;
  logic b_en = 0, b_we = 0; logic [8:0] b_addr = 0; logic [31:0] b_din = 0;
  logic [3:0] b_pin = 0; logic [31:0] b_dout; logic [3:0] b_pout;

  dpr_aspect_ram #(.WIDTH_A(8), .WIDTH_B(32), .MODE_A(WM_WRITE_FIRST),
                   .MODE_B(WM_READ_FIRST)) dut_i (
    .clk_a(clk_a), .rst_n_a(rst_n_a), .en_a(a_en), .we_a(a_we), .addr_a(a_addr),
    .din_a(a_din), .par_in_a(a_pin), .dout_a(a_dout), .par_out_a(a_pout),
    .clk_b(clk_b), .rst_n_b(rst_n_b), .en_b(b_en), .we_b(b_we), .addr_b(b_addr),
    .din_b(b_din), .par_in_b(b_pin), .dout_b(b_dout), .par_out_b(b_pout));

  // DUT 2: A = 4 bit, held-output mode; B = 16 bit, old-data mode
  logic c_en = 0, c_we = 0; logic [11:0] c_addr = 0; logic [3:0] c_din = 0;
  logic [0:0] c_pin = 0; logic [3:0] c_dout; logic [0:0] c_pout;
  logic d_en = 0, d_we = 0; logic [9:0] d_addr = 0; logic [15:0] d_din = 0;
  logic [1:0] d_pin = 0; logic [15:0] d_dout; logic [1:0] d_pout;

  dpr_aspect_ram #(.WIDTH_A(4), .WIDTH_B(16), .MODE_A(WM_NO_CHANGE),
                   .MODE_B(WM_READ_FIRST)) dut_nc_i (
    .clk_a(clk_a), .rst_n_a(rst_n_a), .en_a(c_en), .we_a(c_we), .addr_a(c_addr),
    .din_a(c_din), .par_in_a(c_pin), .dout_a(c_dout), .par_out_a(c_pout),
    .clk_b(clk_b), .rst_n_b(rst_n_b), .en_b(d_en), .we_b(d_we), .addr_b(d_addr),
    .din_b(d_din), .par_in_b(d_pin), .dout_b(d_dout), .par_out_b(d_pout));

  typedef struct packed {
    logic we; logic [10:0] addr; logic [7:0] din; logic p;
    logic [7:0] ed; logic ep;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 11'h000, 8'h11, 1'b1, 8'h11, 1'b1},
    '{1'b1, 11'h001, 8'h22, 1'b0, 8'h22, 1'b0},
    '{1'b1, 11'h002, 8'h33, 1'b1, 8'h33, 1'b1},
    '{1'b1, 11'h003, 8'h44, 1'b0, 8'h44, 1'b0},
    '{1'b0, 11'h000, 8'h00, 1'b0, 8'h11, 1'b1},
    '{1'b0, 11'h003, 8'h00, 1'b0, 8'h44, 1'b0},
    '{1'b1, 11'h7FF, 8'hA5, 1'b1, 8'hA5, 1'b1},
    '{1'b0, 11'h7FF, 8'h00, 1'b0, 8'hA5, 1'b1}
  };

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op_a(input logic en, input logic we, input logic [10:0] ad,
                      input logic [7:0] dt, input logic p);
    @(negedge clk_a); a_en = en; a_we = we; a_addr = ad; a_din = dt; a_pin = p;
    @(posedge clk_a); #1; a_en = 0; a_we = 0;
  endtask

  task automatic op_b(input logic we, input logic [8:0] ad,
                      input logic [31:0] dt, input logic [3:0] p);
    @(negedge clk_b); b_en = 1; b_we = we; b_addr = ad; b_din = dt; b_pin = p;
    @(posedge clk_b); #1; b_en = 0; b_we = 0;
  endtask

  task automatic op_c(input logic we, input logic [11:0] ad, input logic [3:0] dt);
    @(negedge clk_a); c_en = 1; c_we = we; c_addr = ad; c_din = dt; c_pin = 1'b1;
    @(posedge clk_a); #1; c_en = 0; c_we = 0;
  endtask

  task automatic op_d(input logic we, input logic [9:0] ad,
                      input logic [15:0] dt, input logic [1:0] p);
    @(negedge clk_b); d_en = 1; d_we = we; d_addr = ad; d_din = dt; d_pin = p;
    @(posedge clk_b); #1; d_en = 0; d_we = 0;
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_a);
    #1;
    check("R9 reset dout_a", 36'({a_pout, a_dout}), 36'h0);
    check("R9 reset dout_b", 36'({b_pout, b_dout}), 36'h0);
    check("R1 addr width 8-bit port", 36'($bits(a_addr)), 36'd11);
    check("R1 addr width 32-bit port", 36'($bits(dut_i.addr_b)), 36'd9);
    check("R1 addr width 4-bit port", 36'($bits(dut_nc_i.addr_a)), 36'd12);
    check("R1 parity width 16-bit port", 36'($bits(dut_nc_i.par_out_b)), 36'd2);
    @(negedge clk_a); rst_n_a = 1'b1; rst_n_b = 1'b1;

    // Table walk: R2 stores, R5 write shows new data, R4 reads
    for (int i = 0; i < 8; i++) begin
      op_a(1'b1, VEC[i].we, VEC[i].addr, VEC[i].din, VEC[i].p);
      check(VEC[i].we ? "R5 write-first vector" : "R2/R4 read vector",
            36'({a_pout, a_dout}), 36'({VEC[i].ep, VEC[i].ed}));
    end

    // R10 / R3: 32-bit view of bytes 0..3 with their parity bits
    op_b(1'b0, 9'h000, 32'h0, 4'h0);
    check("R10 wide read of narrow writes", 36'(b_dout), 36'h44332211);
    check("R3 parity lanes by byte", 36'(b_pout), 36'h5);

    // R6: old-data write shows previous contents
    op_b(1'b1, 9'h000, 32'hDEADBEEF, 4'hA);
    check("R6 read-first write output", 36'({b_pout, b_dout}), 36'h544332211);

    // R10 / R3: narrow read of the wide write
    op_a(1'b1, 1'b0, 11'h002, 8'h0, 1'b0);
    check("R10 narrow read byte 2", 36'({a_pout, a_dout}), 36'h0AD);
    op_a(1'b1, 1'b0, 11'h001, 8'h0, 1'b0);
    check("R3 narrow read byte 1 with parity", 36'({a_pout, a_dout}), 36'h1BE);

    // R8: enable low ignores a write request
    op_a(1'b0, 1'b1, 11'h000, 8'hFF, 1'b1);
    check("R8 disabled output hold", 36'({a_pout, a_dout}), 36'h1BE);
    op_a(1'b1, 1'b0, 11'h000, 8'h0, 1'b0);
    check("R8 disabled write not stored", 36'({a_pout, a_dout}), 36'h0EF);

    // Second DUT: 16-bit setup, 4-bit views, held-output mode
    op_d(1'b1, 10'h000, 16'h1234, 2'b10);
    op_d(1'b1, 10'h001, 16'h5678, 2'b00);
    op_d(1'b0, 10'h000, 16'h0, 2'b00);
    check("R4 16-bit read", 36'({d_pout, d_dout}), 36'h21234);
    op_c(1'b0, 12'h000, 4'h0);
    check("R10 4-bit read nibble 0", 36'(c_dout), 36'h4);
    op_c(1'b0, 12'h003, 4'h0);
    check("R10 4-bit read nibble 3", 36'(c_dout), 36'h1);
    check("R1 parity output of sub-byte port", 36'(c_pout), 36'h0);
    op_c(1'b0, 12'h002, 4'h0);
    check("R10 4-bit read nibble 2", 36'(c_dout), 36'h2);
    op_c(1'b1, 12'h000, 4'h9);
    check("R7 no-change write output", 36'(c_dout), 36'h2);

    // R11: same-cycle writes to disjoint lanes of one row
    fork
      op_c(1'b1, 12'h001, 4'hC);
      op_d(1'b1, 10'h001, 16'hCAFE, 2'b01);
    join
    check("R7 no-change during concurrent write", 36'(c_dout), 36'h2);
    check("R6 old data during concurrent write", 36'({d_pout, d_dout}), 36'h05678);
    op_d(1'b0, 10'h000, 16'h0, 2'b00);
    check("R11 low half keeps both narrow writes", 36'({d_pout, d_dout}), 36'h212C9);
    op_d(1'b0, 10'h001, 16'h0, 2'b00);
    check("R11 high half from wide write", 36'({d_pout, d_dout}), 36'h1CAFE);
    op_c(1'b0, 12'h001, 4'h0);
    check("R11 narrow view of narrow write", 36'(c_dout), 36'hC);

    // R9: mid-run reset clears output, not storage
    @(negedge clk_a); rst_n_a = 1'b0;
    #1;
    check("R9 async reset clears output", 36'({a_pout, a_dout}), 36'h0);
    @(negedge clk_a); rst_n_a = 1'b1;
    op_a(1'b1, 1'b0, 11'h002, 8'h0, 1'b0);
    check("R9 storage survives reset", 36'({a_pout, a_dout}), 36'h0AD);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule